// File: doc/BRIEF.md
# Dual Converter Status and Result Register Unit

This block is the register-side front end for two converter channels, a primary (channel 0) and an auxiliary (channel 1). Each converter core signals the end of an operation with a one-cycle done strobe. For a conversion, the strobe comes with a 16-bit result and overrange and underrange indications. For a calibration, it comes with offset and gain coefficients and a fault indication. The unit stores these words as byte-wide registers that a host reads over an 8-bit register bus.

A shared status byte reports the state of both channels. It holds a ready flag per channel, a calibration-done flag, a missing-reference flag and a clamp-error flag per channel. A channel whose ready flag is set is locked: any completion that arrives while the flag is set is dropped, so the host reads a consistent set of values. Software releases the lock in one of two ways. It can clear the ready bit directly, or it can write the mode register to start a new operation, which also clears the error flag of the started channel and the shared calibration flag.

Bus reads are combinational from `bus_addr`. Bus writes take effect on the rising clock edge while `bus_wr` is high.

Top module: `conv_status_regs`

## Requirements
- R1: After reset, the status byte, the mode register and all twelve data bytes read 0x00.
- R2: The status byte (address 0x0) holds the following bits. Bit 7 is primary ready, bit 6 is auxiliary ready, bit 5 is calibration done and bit 4 is missing reference. Bit 3 is primary error and bit 2 is auxiliary error. Bits 1 and 0 always read 0.
- R3: A done strobe on a channel whose ready flag is clear sets that ready flag on the next edge. This applies to both a conversion and a calibration.
- R4: Writing the status byte clears the ready flag of channel c when data bit (7-c) is 0; a 1 leaves the flag unchanged. The mode register (address 0x1) has the following fields: bits [1:0] are the primary operation, bits [3:2] are the auxiliary operation, and bit 4 selects the external reference. A mode write whose field for a channel is 01 (convert) or 10 (calibrate) starts that channel. Starting a channel clears its ready and error flags, and clears the calibration flag.
- R5: While a channel's ready flag is set, its done strobes are dropped. Its result, offset and gain bytes and its error flag stay unchanged, and the calibration flag is not set.
- R6: An accepted calibration completion sets the calibration flag. A status-byte write never clears that flag.
- R7: The missing-reference flag equals, one cycle later, the `ref_missing` input ANDed with "some channel's mode field is non-zero".
- R8: When the missing-reference flag, mode bit 4 and that channel's non-zero mode field are all set, an accepted conversion stores 0xFFFF and sets the channel's error flag.
- R9: Otherwise, an accepted conversion behaves as follows. With overrange it stores 0xFFFF and sets error. With underrange only, it stores 0x0000 and sets error. With neither, it stores the core result. Overrange has priority over underrange.
- R10: An accepted calibration with fault sets the error flag and leaves both coefficients unchanged. Without fault, it writes both the offset and the gain coefficient.
- R11: The data bytes for channel c sit at 2+6c (result low), 3+6c (result high), 4+6c (offset low), 5+6c (offset high), 6+6c (gain low) and 7+6c (gain high). Mode bits 7:5 and all other addresses read 0. Writes to addresses other than 0 and 1 have no effect.
- R12: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| core_done | input | 2 | Per-channel completion strobe |
| core_is_cal | input | 2 | Completion is a calibration |
| core_ovr | input | 2 | Conversion overrange |
| core_unr | input | 2 | Conversion underrange |
| core_cal_fault | input | 2 | Calibration fault |
| core_result | input | 32 | Results, channel c in bits [16c+15:16c] |
| core_offset | input | 32 | Offset coefficients, same packing |
| core_gain | input | 32 | Gain coefficients, same packing |
| ref_missing | input | 1 | External reference absent or too low |

## Verification
The hardest situations to reach are the collisions between software and hardware in the same cycle. In one, a done strobe lands in the very cycle a status write clears the ready flag. In another, it lands in the cycle a mode write starts the channel. In a third, a completion lands in the cycle that the ready flag is released. The stimulus tasks let the bench raise a done strobe and a bus write together, so the bench creates each of these collisions on purpose. A behavioural model, updated on every edge, predicts the outcome of each collision, and the bench compares that prediction with the read data every cycle. The forced-ones case needs three things at once: the reference flag has to be registered first, the external-reference mode bit has to be set, and the channel has to be active. The stimulus builds these up in sequence before the conversion arrives.

// File: rtl/convstat_pkg.sv
`timescale 1ns/1ps
package convstat_pkg;
    localparam int unsigned CH_N        = 2;
    localparam int unsigned WORD_W      = 16;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned ADDR_W      = 4;
    localparam int unsigned OP_W        = 2;
    localparam int unsigned WORD_BYTES  = WORD_W / BYTE_W;
    localparam int unsigned WORDS_PER_CH = 3;
    localparam int unsigned REGS_PER_CH = WORDS_PER_CH * WORD_BYTES;
    localparam int unsigned A_STAT      = 0;
    localparam int unsigned A_MODE      = 1;
    localparam int unsigned A_DATA_BASE = 2;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE = 2'b00,
        OP_CONV = 2'b01,
        OP_CAL  = 2'b10,
        OP_RSV  = 2'b11
    } op_e;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic [WORD_W-1:0] off;
        logic [WORD_W-1:0] gain;
    } chan_regs_t;

    typedef struct packed {
        logic                           ext_ref;
        logic [CH_N-1:0][OP_W-1:0]      op;
    } mode_t;

    typedef struct packed {
        logic [CH_N-1:0] rdy;
        logic            cal;
        logic            noref;
        logic [CH_N-1:0] err;
    } stat_t;

    localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/conv_chan_regs.sv
`timescale 1ns/1ps
module conv_chan_regs
    import convstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              is_cal,
    input  logic              ovr,
    input  logic              unr,
    input  logic              fault,
    input  logic              force_ones,
    input  logic              inhibit,
    input  logic [WORD_W-1:0] result_in,
    input  logic [WORD_W-1:0] offset_in,
    input  logic [WORD_W-1:0] gain_in,
    output logic              acc_conv,
    output logic              acc_cal,
    output logic              err_hit,
    output chan_regs_t        regs_q
);
    chan_regs_t regs_d;
    logic       accept;

    always_comb begin
        regs_d   = regs_q;
        err_hit  = 1'b0;
        accept   = done && !inhibit;
        acc_conv = accept && !is_cal;
        acc_cal  = accept && is_cal;
        if (acc_conv) begin
            if (force_ones || ovr) begin
                regs_d.res = '1;
                err_hit    = 1'b1;
            end else if (unr) begin
                regs_d.res = '0;
                err_hit    = 1'b1;
            end else begin
                regs_d.res = result_in;
            end
        end
        if (acc_cal) begin
            if (fault) begin
                err_hit = 1'b1;
            end else begin
                regs_d.off  = offset_in;
                regs_d.gain = gain_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/conv_read_mux.sv
`timescale 1ns/1ps
module conv_read_mux
    import convstat_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BYTE_W-1:0]      stat_byte,
    input  logic [BYTE_W-1:0]      mode_byte,
    input  chan_regs_t [CH_N-1:0]  chan,
    output logic [BYTE_W-1:0]      rdata
);
    function automatic logic [WORD_W-1:0] pick_word(chan_regs_t r, int unsigned w);
        case (w)
            0:       return r.res;
            1:       return r.off;
            default: return r.gain;
        endcase
    endfunction

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_STAT)) rdata = stat_byte;
        if (addr == ADDR_W'(A_MODE)) rdata = mode_byte;
        for (int c = 0; c < CH_N; c++) begin
            for (int w = 0; w < WORDS_PER_CH; w++) begin
                for (int b = 0; b < WORD_BYTES; b++) begin
                    if (addr == ADDR_W'(A_DATA_BASE + c*REGS_PER_CH + w*WORD_BYTES + b))
                        rdata = pick_word(chan[c], w)[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end
endmodule

// File: rtl/conv_status_regs.sv
`timescale 1ns/1ps
module conv_status_regs
    import convstat_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [CH_N-1:0]          core_done,
    input  logic [CH_N-1:0]          core_is_cal,
    input  logic [CH_N-1:0]          core_ovr,
    input  logic [CH_N-1:0]          core_unr,
    input  logic [CH_N-1:0]          core_cal_fault,
    input  logic [CH_N*WORD_W-1:0]   core_result,
    input  logic [CH_N*WORD_W-1:0]   core_offset,
    input  logic [CH_N*WORD_W-1:0]   core_gain,
    input  logic                     ref_missing
);
    typedef struct packed {
        stat_t stat;
        mode_t mode;
    } ctl_t;

    ctl_t                  q, d;
    logic                  wr_stat, wr_mode;
    logic [CH_N-1:0]       start, active, force_ones;
    logic [CH_N-1:0]       acc_conv, acc_cal, err_hit;
    chan_regs_t [CH_N-1:0] chan_q;
    logic [CH_N*WORD_W-1:0] res_flat;
    logic [BYTE_W-1:0]     stat_byte, mode_byte;

    always_comb begin
        wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));
        wr_mode = bus_wr && (bus_addr == ADDR_W'(A_MODE));
        for (int c = 0; c < CH_N; c++) begin
            start[c] = wr_mode &&
                       ((bus_wdata[c*OP_W +: OP_W] == OP_CONV) ||
                        (bus_wdata[c*OP_W +: OP_W] == OP_CAL));
            active[c]     = (q.mode.op[c] != OP_IDLE);
            force_ones[c] = q.stat.noref && q.mode.ext_ref && active[c];
        end

        d = q;
        // software and indirect clears first
        for (int c = 0; c < CH_N; c++) begin
            if (wr_stat && !bus_wdata[BYTE_W-1-c]) d.stat.rdy[c] = 1'b0;
            if (start[c]) begin
                d.stat.rdy[c] = 1'b0;
                d.stat.err[c] = 1'b0;
            end
        end
        if (|start) d.stat.cal = 1'b0;
        // hardware sets override clears in the same cycle
        for (int c = 0; c < CH_N; c++) begin
            if (acc_conv[c] || acc_cal[c]) d.stat.rdy[c] = 1'b1;
            if (err_hit[c])                d.stat.err[c] = 1'b1;
            if (acc_cal[c])                d.stat.cal    = 1'b1;
        end
        d.stat.noref = ref_missing && (|active);
        if (wr_mode) d.mode = mode_t'(bus_wdata[MODE_W-1:0]);

        stat_byte = {q.stat.rdy[0], q.stat.rdy[1], q.stat.cal, q.stat.noref,
                     q.stat.err[0], q.stat.err[1], 2'b00};
        mode_byte = BYTE_W'(q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        conv_chan_regs u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .done       (core_done[c]),
            .is_cal     (core_is_cal[c]),
            .ovr        (core_ovr[c]),
            .unr        (core_unr[c]),
            .fault      (core_cal_fault[c]),
            .force_ones (force_ones[c]),
            .inhibit    (q.stat.rdy[c]),
            .result_in  (core_result[c*WORD_W +: WORD_W]),
            .offset_in  (core_offset[c*WORD_W +: WORD_W]),
            .gain_in    (core_gain[c*WORD_W +: WORD_W]),
            .acc_conv   (acc_conv[c]),
            .acc_cal    (acc_cal[c]),
            .err_hit    (err_hit[c]),
            .regs_q     (chan_q[c])
        );
        assign res_flat[c*WORD_W +: WORD_W] = chan_q[c].res;
    end

    conv_read_mux u_rd (
        .addr      (bus_addr),
        .stat_byte (stat_byte),
        .mode_byte (mode_byte),
        .chan      (chan_q),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/conv_status_chk.sv
`timescale 1ns/1ps
module conv_status_chk
    import convstat_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [CH_N-1:0]        core_done,
    input logic [CH_N-1:0]        core_is_cal,
    input logic [CH_N-1:0]        core_ovr,
    input logic [CH_N-1:0]        core_unr,
    input logic                   ref_missing,
    input logic [BYTE_W-1:0]      stat_byte,
    input logic [CH_N-1:0]        active,
    input logic [CH_N-1:0]        start,
    input logic [CH_N*WORD_W-1:0] res_flat
);
    for (genvar c = 0; c < CH_N; c++) begin : g_chk
        p_ready_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            core_done[c] && !stat_byte[BYTE_W-1-c] |=> stat_byte[BYTE_W-1-c]);

        p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            start[c] && !core_done[c] |=> !stat_byte[BYTE_W-1-c] && !stat_byte[3-c]);

        p_locked_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
            stat_byte[BYTE_W-1-c] |=> $stable(res_flat[c*WORD_W +: WORD_W]));

        p_cal_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            core_done[c] && core_is_cal[c] && !stat_byte[BYTE_W-1-c] |=> stat_byte[5]);

        p_clamp_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
            core_done[c] && !core_is_cal[c] && !stat_byte[BYTE_W-1-c] &&
            (core_ovr[c] || core_unr[c]) |=> stat_byte[3-c]);
    end

    p_noref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_byte[4] == $past(ref_missing && (|active)));

    p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[1:0] == 2'b00);
endmodule

bind conv_status_regs conv_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_done   (core_done),
    .core_is_cal (core_is_cal),
    .core_ovr    (core_ovr),
    .core_unr    (core_unr),
    .ref_missing (ref_missing),
    .stat_byte   (stat_byte),
    .active      (active),
    .start       (start),
    .res_flat    (res_flat)
);

// File: tb/sim_conv_status_regs.sv
`timescale 1ns/1ps
module sim_conv_status_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  core_done = '0, core_is_cal = '0, core_ovr = '0, core_unr = '0, core_cal_fault = '0;
    logic [31:0] core_result = '0, core_offset = '0, core_gain = '0;
    logic        ref_missing = 1'b0;

    always #2.5 clk = ~clk;

    conv_status_regs u0 (.*);

    // behavioural reference state
    bit          m_rdy[2], m_err[2], m_cal, m_noref;
    logic [4:0]  m_mode;
    logic [15:0] m_res[2], m_off[2], m_gain[2];
    int          n_cmp = 0, n_bad = 0;
    string       cur_req = "R1";
    bit          finished = 0;

    function automatic logic [7:0] model_read(logic [3:0] a);
        int c, k;
        if (a == 0) return {m_rdy[0], m_rdy[1], m_cal, m_noref, m_err[0], m_err[1], 2'b00};
        if (a == 1) return {3'b000, m_mode};
        if (a >= 2 && a <= 13) begin
            c = (a - 2) / 6;
            k = (a - 2) % 6;
            case (k)
                0: return m_res[c][7:0];
                1: return m_res[c][15:8];
                2: return m_off[c][7:0];
                3: return m_off[c][15:8];
                4: return m_gain[c][7:0];
                default: return m_gain[c][15:8];
            endcase
        end
        return 8'h00;
    endfunction

    task automatic model_update();
        bit n_rdy[2], n_err[2], n_cal, st[2], act[2], wrs, wrm;
        logic [4:0] n_mode;
        if (!rst_n) begin
            foreach (m_rdy[c]) begin
                m_rdy[c] = 0; m_err[c] = 0; m_res[c] = 0; m_off[c] = 0; m_gain[c] = 0;
            end
            m_cal = 0; m_noref = 0; m_mode = 0;
            return;
        end
        n_rdy = m_rdy; n_err = m_err; n_cal = m_cal; n_mode = m_mode;
        wrs = bus_wr && bus_addr == 0;
        wrm = bus_wr && bus_addr == 1;
        for (int c = 0; c < 2; c++) begin
            st[c]  = wrm && (bus_wdata[2*c +: 2] == 2'b01 || bus_wdata[2*c +: 2] == 2'b10);
            act[c] = m_mode[2*c +: 2] != 2'b00;
        end
        for (int c = 0; c < 2; c++) begin
            if (wrs && !bus_wdata[7-c]) n_rdy[c] = 0;
            if (st[c]) begin n_rdy[c] = 0; n_err[c] = 0; end
        end
        if (st[0] || st[1]) n_cal = 0;
        for (int c = 0; c < 2; c++) begin
            if (core_done[c] && !m_rdy[c]) begin
                n_rdy[c] = 1;
                if (!core_is_cal[c]) begin
                    if ((m_noref && m_mode[4] && act[c]) || core_ovr[c]) begin
                        m_res[c] = 16'hFFFF; n_err[c] = 1;
                    end else if (core_unr[c]) begin
                        m_res[c] = 16'h0000; n_err[c] = 1;
                    end else begin
                        m_res[c] = core_result[16*c +: 16];
                    end
                end else begin
                    n_cal = 1;
                    if (core_cal_fault[c]) n_err[c] = 1;
                    else begin
                        m_off[c]  = core_offset[16*c +: 16];
                        m_gain[c] = core_gain[16*c +: 16];
                    end
                end
            end
        end
        m_noref = ref_missing && (act[0] || act[1]);
        if (wrm) n_mode = bus_wdata[4:0];
        m_rdy = n_rdy; m_err = n_err; m_cal = n_cal; m_mode = n_mode;
    endtask

    task automatic check_now();
        logic [7:0] exp;
        exp = model_read(bus_addr);
        n_cmp++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0h actual=%02h expected=%02h", cur_req, bus_addr, bus_rdata, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_now();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0; bus_addr = 4'h0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_addr = a;
        #1;
        check_now();
        bus_addr = 4'h0;
        #1;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 16; a++) rd(4'(a));
    endtask

    // set up a completion for channel c; caller pulses it with cyc()
    task automatic arm(input int c, input bit cal, input logic [15:0] res,
                       input bit ovr, input bit unr, input bit flt,
                       input logic [15:0] off, input logic [15:0] gn);
        core_done[c] = 1'b1; core_is_cal[c] = cal; core_ovr[c] = ovr;
        core_unr[c] = unr; core_cal_fault[c] = flt;
        core_result[16*c +: 16] = res; core_offset[16*c +: 16] = off;
        core_gain[16*c +: 16] = gn;
    endtask

    task automatic disarm();
        core_done = '0; core_is_cal = '0; core_ovr = '0; core_unr = '0; core_cal_fault = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        rd_all();

        // R3, R11: primary conversion
        cur_req = "R3";
        wr(4'h1, 8'h01);
        arm(0, 0, 16'h1234, 0, 0, 0, 0, 0); cyc(); disarm();
        cyc();
        cur_req = "R11"; rd_all();

        // R5: completion dropped while locked
        cur_req = "R5";
        arm(0, 0, 16'h5555, 1, 0, 0, 0, 0); cyc(); disarm();
        arm(0, 1, 0, 0, 0, 0, 16'hAAAA, 16'hBBBB); cyc(); disarm();
        rd_all();

        // R4: software clear by status write; a 1 bit keeps the flag
        cur_req = "R4";
        arm(1, 0, 16'h0F0F, 0, 0, 0, 0, 0); cyc(); disarm();
        wr(4'h0, 8'h80);
        wr(4'h0, 8'h00);
        cyc();

        // R9: overrange, underrange, priority
        cur_req = "R9";
        wr(4'h1, 8'h05);
        arm(1, 0, 16'h1111, 1, 0, 0, 0, 0); cyc(); disarm();
        arm(0, 0, 16'h2222, 0, 1, 0, 0, 0); cyc(); disarm();
        rd_all();
        wr(4'h0, 8'h00);
        arm(0, 0, 16'h3333, 1, 1, 0, 0, 0); cyc(); disarm();
        rd(4'h2); rd(4'h3);

        // R4: mode start clears ready and error of started channel only
        cur_req = "R4";
        wr(4'h1, 8'h04);
        rd_all();

        // R6, R10: auxiliary calibration
        cur_req = "R10";
        wr(4'h1, 8'h08);
        arm(1, 1, 0, 0, 0, 0, 16'hC0DE, 16'hBEEF); cyc(); disarm();
        rd_all();
        cur_req = "R6";
        wr(4'h0, 8'h00);
        cyc();
        cur_req = "R10";
        arm(1, 1, 0, 0, 0, 1, 16'h9999, 16'h8888); cyc(); disarm();
        rd_all();

        // R7: reference flag follows input and activity
        cur_req = "R7";
        wr(4'h1, 8'h00);
        wr(4'h0, 8'h00);
        ref_missing = 1'b1; cyc(); cyc();
        wr(4'h1, 8'h01);
        cyc(); cyc();
        ref_missing = 1'b0; cyc(); cyc();

        // R8: forced all ones with external reference
        cur_req = "R8";
        ref_missing = 1'b1;
        wr(4'h1, 8'h11);
        wr(4'h0, 8'h00);
        cyc();
        arm(0, 0, 16'h4242, 0, 0, 0, 0, 0); cyc(); disarm();
        rd_all();
        // same setting but internal reference: no forcing
        wr(4'h1, 8'h01);
        cyc();
        arm(0, 0, 16'h4242, 0, 0, 0, 0, 0); cyc(); disarm();
        rd(4'h2); rd(4'h3); rd(4'h0);
        ref_missing = 1'b0;

        // R12: same-cycle set and clear
        cur_req = "R12";
        wr(4'h0, 8'h00);
        bus_addr = 4'h0; bus_wdata = 8'h00; bus_wr = 1'b1;
        arm(0, 0, 16'h7777, 0, 0, 0, 0, 0);
        cyc(); disarm(); bus_wr = 1'b0;
        rd_all();
        wr(4'h0, 8'h00);
        bus_addr = 4'h1; bus_wdata = 8'h09; bus_wr = 1'b1;
        arm(1, 1, 0, 0, 0, 0, 16'h1357, 16'h2468);
        cyc(); disarm(); bus_wr = 1'b0; bus_addr = 4'h0;
        rd_all();
        // completion in the cycle the lock is released is dropped
        bus_addr = 4'h0; bus_wdata = 8'h00; bus_wr = 1'b1;
        arm(0, 0, 16'h6666, 0, 0, 0, 0, 0);
        cyc(); disarm(); bus_wr = 1'b0;
        rd(4'h2); rd(4'h3);

        // R11: writes to data addresses ignored; R2 reserved bits
        cur_req = "R11";
        wr(4'h2, 8'hAB); wr(4'h7, 8'hCD); wr(4'hF, 8'hEF);
        rd_all();
        cur_req = "R2";
        wr(4'h0, 8'hFF);
        rd(4'h0);

        finish_run();
    end
endmodule